// File: doc/BRIEF.md
# Toggle-Kicked Watchdog Timer

This block watches a kick line driven by a processor and lowers an active-low flag when the line has not changed level for a set number of clock cycles. A rising edge and a falling edge both count as a kick. The kick line is brought into the clock domain through a two-flop synchronizer. The edge detector compares the synchronized level with its copy from the previous cycle.

The counter stays cleared and idle while a float indicator reports the kick pin as undriven, and while the reset generator holds the system in reset. After either condition ends, counting starts again only on the next kick transition. A timeout latches the flag low, and only a later kick transition raises it again. When the supply-good input is low, the flag is forced low through a combinational path, so it rises again in the same cycle that supply-good returns. The timeout length `WD_CYCLES` is a parameter given in clock cycles. It would normally be set to about 1.6 s worth of cycles, and anything from 1.0 s to 2.25 s is acceptable.

Top module: `kick_watchdog`

## Requirements
- R1: After the synchronous power-on clear (`rst_n` low), `wd_out_n_o` is high, the counter is idle, and the synchronizer history is loaded from the current kick level, so a kick held at a steady level afterwards never produces a timeout.
- R2: With `kick_float_i` and `sys_reset_i` both low, a rising or a falling transition on `kick_i` clears the counter and starts a new countdown. If kicks are spaced at most `WD_CYCLES` cycles apart, `wd_out_n_o` stays high.
- R3: Let a change on `kick_i` be set up before clock edge 1. If `kick_i` then holds its level, `wd_out_n_o` is still high after edge `WD_CYCLES`+2 and is low after edge `WD_CYCLES`+3. That is two synchronizer cycles, one edge-sampling cycle and `WD_CYCLES` idle cycles.
- R4: Once a timeout has occurred, `wd_out_n_o` stays low for as long as `kick_i` holds its level. After a transition it is high again after the third clock edge.
- R5: While `kick_float_i` is 1, the counter is held cleared and produces no timeout. After it returns to 0, counting resumes only on the next kick transition.
- R6: While `sys_reset_i` is 1, the counter is held cleared. After it returns to 0, no timeout occurs until a kick transition has been seen and `WD_CYCLES` further idle cycles have passed.
- R7: While `supply_ok_i` is 0, `wd_out_n_o` is 0 in the same cycle. When `supply_ok_i` returns to 1, `wd_out_n_o` is 1 at once unless a timeout is latched.
- R8: A kick level that lasts two clock cycles is seen as two transitions. Each one restarts the countdown, so the timeout comes `WD_CYCLES` idle cycles after the second transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| kick_i | input | 1 | Asynchronous kick line from the processor |
| kick_float_i | input | 1 | 1 = kick pin undriven, watchdog disabled |
| sys_reset_i | input | 1 | 1 = reset generator asserting system reset |
| supply_ok_i | input | 1 | 1 = supply above threshold |
| wd_out_n_o | output | 1 | Active-low watchdog flag |

## Verification
The bench builds the block with `WD_CYCLES` = 40, where the default is about 1.6 s of cycles. This keeps each timeout to a few dozen cycles, so exact expiry edges, latched timeouts, several expirations and restarts can all be reached within a short run. Random kick gaps with a mean of 60 cycles land on both sides of the timeout. The float, system-reset and supply pulses that are mixed in then overlap running, expired and idle counters.

// File: rtl/kwd_pkg.sv
// Package: shared types for the toggle-kicked watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package kwd_pkg;

    // Countdown state: idle (not yet kicked), running, or timed out.
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_RUN     = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

    // Width needed to hold a count from 0 up to n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/kwd_sync.sv
// Module: kwd_sync
// Brings the asynchronous kick line into the clock domain through a chain of STAGES flops.
// Assumes: on power-on clear every stage is loaded with the present raw level, so no
// transition is seen at release.
module kwd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the chain; preload on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{raw_i}};
        else        chain_q <= {chain_q[STAGES-2:0], raw_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/kwd_edge.sv
// Module: kwd_edge
// Reports a transition of either polarity on the synchronized kick level.
// Assumes: init_i carries the raw kick level so the history matches the synchronizer at clear.
module kwd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic level_i,
    output logic edge_o
);
    logic prev_q;

    // Keep the previous-cycle copy of the synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= init_i;
        else        prev_q <= level_i;
    end

    assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/kwd_timer.sv
// Module: kwd_timer
// Countdown with latched expiry. A kick restarts it; hold clears it to idle.
// Assumes: hold_i and kick_i are synchronous to clk; LIMIT_CYCLES >= 2.
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int unsigned LIMIT_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic hold_i,
    output logic expired_o,
    output logic running_o
);
    localparam int unsigned CW = cnt_width(LIMIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(LIMIT_CYCLES - 1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state choice: kicks restart, hold forces idle, expiry latches.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_IDLE: begin
                cnt_d = '0;
                if (kick_i && !hold_i) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (hold_i) begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end else if (kick_i) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    state_d = WD_EXPIRED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_EXPIRED: begin
                cnt_d = '0;
                if (kick_i) state_d = hold_i ? WD_IDLE : WD_RUN;
            end
            default: begin
                state_d = WD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and count registers with power-on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign expired_o = (state_q == WD_EXPIRED);
    assign running_o = (state_q == WD_RUN);

    // A kick outside hold restarts the count from zero in the running state.
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && !hold_i) |=> (state_q == WD_RUN && cnt_q == '0));

    // The count never passes the last cycle of the window.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Expiry follows only a full window.
    assert_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> ($past(cnt_q) == LAST && $past(running_o)));

    // The latched timeout survives until a kick.
    assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !kick_i) |=> expired_o);

    // Hold leaves the counter not running.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !running_o);
endmodule

// File: rtl/kick_watchdog.sv
// Module: kick_watchdog (top)
// Watchdog kicked by any transition on kick_i. It drives an active-low flag that latches
// on timeout and is forced low combinationally while the supply is not good.
// Assumes: kick_float_i, sys_reset_i and supply_ok_i are synchronous to clk.
module kick_watchdog #(
    parameter int unsigned WD_CYCLES   = 160_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic kick_float_i,
    input  logic sys_reset_i,
    input  logic supply_ok_i,
    output logic wd_out_n_o
);
    logic kick_sync, kick_edge, hold, expired, running;

    assign hold = kick_float_i | sys_reset_i;

    kwd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(kick_i), .sync_o(kick_sync)
    );

    kwd_edge i_edge (
        .clk(clk), .rst_n(rst_n), .init_i(kick_i),
        .level_i(kick_sync), .edge_o(kick_edge)
    );

    kwd_timer #(.LIMIT_CYCLES(WD_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_edge), .hold_i(hold),
        .expired_o(expired), .running_o(running)
    );

    assign wd_out_n_o = supply_ok_i & ~expired;

    // A floated kick pin stops the countdown by the next cycle.
    assert_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_float_i |=> !running);

    // The flag rises only when the supply is good and a kick was seen, or the supply returned.
    assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_out_n_o) |-> ($rose(supply_ok_i) || $past(kick_edge)));

    // The first cycle after clear shows an idle, non-expired counter.
    assert_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!expired && !running));
endmodule

// File: tb/test_kick_watchdog.sv
module test_kick_watchdog;
    localparam int unsigned W = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0, flt = 1'b0, srst = 1'b0, sup = 1'b1;
    logic wd_n;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kick_watchdog #(.WD_CYCLES(W)) i_kick_watchdog (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .kick_float_i(flt),
        .sys_reset_i(srst), .supply_ok_i(sup), .wd_out_n_o(wd_n)
    );

    // Behavioural reference: 0 idle, 1 running, 2 expired.
    logic m_k1, m_k2, m_kp;
    int   m_st, m_cnt;

    function automatic int next_state(input int st, input int cnt, input bit ev, input bit hd);
        if (st == 2) return ev ? (hd ? 0 : 1) : 2;
        if (hd) return 0;
        if (ev) return 1;
        if (st == 1 && cnt == W - 1) return 2;
        return st;
    endfunction

    function automatic int next_count(input int st, input int cnt, input bit ev, input bit hd);
        if (st == 1 && !hd && !ev && cnt != W - 1) return cnt + 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k1 <= kick; m_k2 <= kick; m_kp <= kick; m_st <= 0; m_cnt <= 0;
        end else begin
            m_st  <= next_state(m_st, m_cnt, m_k2 ^ m_kp, flt | srst);
            m_cnt <= next_count(m_st, m_cnt, m_k2 ^ m_kp, flt | srst);
            m_k1 <= kick; m_k2 <= m_k1; m_kp <= m_k2;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wd_out_n actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        kick = 1'b1;
        steps(3);
        rst_n = 1'b1;
        steps(1);
        check("R1 out high after clear", wd_n, 1'b1);
        steps(3 * W);
        check("R1 steady kick after clear, no timeout", wd_n, 1'b1);

        srst = 1'b1; steps(5); srst = 1'b0;
        steps(2 * W);
        check("R6 no count after system reset without kick", wd_n, 1'b1);

        kick = ~kick;
        steps(W + 2);
        check("R3 still high one cycle before expiry", wd_n, 1'b1);
        steps(1);
        check("R3 low at expiry", wd_n, 1'b0);
        steps(25);
        check("R4 timeout stays latched", wd_n, 1'b0);
        kick = ~kick;
        steps(2);
        check("R4 still low before kick is sampled", wd_n, 1'b0);
        steps(1);
        check("R4 high after kick", wd_n, 1'b1);

        for (int i = 0; i < 8; i++) begin
            steps(W / 2);
            kick = ~kick;
        end
        steps(W / 2);
        check("R2 regular kicks keep flag high", wd_n, 1'b1);

        flt = 1'b1;
        steps(3 * W);
        check("R5 float holds counter", wd_n, 1'b1);
        flt = 1'b0;
        steps(2 * W);
        check("R5 no count after float until kick", wd_n, 1'b1);

        sup = 1'b0; #1;
        check("R7 supply low forces flag low", wd_n, 1'b0);
        steps(3);
        sup = 1'b1; #1;
        check("R7 flag high as soon as supply returns", wd_n, 1'b1);
        @(negedge clk);

        kick = ~kick;
        steps(2);
        kick = ~kick;
        steps(W + 1);
        check("R8 second edge of short pulse restarts (W+3)", wd_n, 1'b1);
        steps(1);
        check("R8 still high (W+4)", wd_n, 1'b1);
        steps(1);
        check("R8 expiry after second edge (W+5)", wd_n, 1'b0);

        kick = ~kick; steps(4);
        srst = 1'b1; steps(2 * W);
        check("R6 system reset holds counter", wd_n, 1'b1);
        srst = 1'b0;

        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 59) == 0)  kick = ~kick;
            if ($urandom_range(0, 199) == 0) flt = ~flt;
            if ($urandom_range(0, 149) == 0) srst = ~srst;
            if ($urandom_range(0, 99) == 0)  sup = ~sup;
            #1;
            check("R2/R3/R4/R5/R6/R7 random vs model", wd_n, sup & (m_st != 2));
            steps(1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule